// File: doc/BRIEF.md
# Byte/Word Configurable Static RAM

A synthesizable behavioural model of a small static RAM whose data organisation can be switched while it runs. In word organisation each address selects a 16-bit word, and two active-low lane enables decide which byte of the bus takes part in a transfer. In byte organisation the top data pin becomes the least significant address bit. That doubles the number of addressable locations, and every transfer then uses only the bottom eight data pins.

Access needs two chip enables of opposite polarity, an active-low write strobe and an active-low output enable. The bidirectional bus is split into an input vector, an output vector and one output-enable bit per byte lane. Storage is written on the rising edge of a model clock. Reads are combinational from the addressed word. Contents are held without refresh, whatever the select state.

Top module: `bwram_top`

## Requirements
- R1: The part is selected only when `ce_n` is 0 and `ce` is 1. While it is not selected, both bits of `dq_oe` are 0 and no clock edge changes the stored contents.
- R2: When the part is selected and `we_n` is 0, the enabled lanes are written at the next rising clock edge whatever the level of `oe_n`, and `dq_oe` stays 0.
- R3: A lane drives the bus only when the part is selected, `we_n` is 1, `oe_n` is 0 and the lane is enabled. In every other case its `dq_oe` bit is 0.
- R4: With `org_word` at 1, `lb_n` low enables lane 0 (data bits 7:0) and `ub_n` low enables lane 1 (data bits 15:8), for both reads and writes. With both high, nothing is driven and nothing is written.
- R5: With `org_word` at 1, `addr` selects one 16-bit word, and the lane 0 and lane 1 bytes of that word appear on `dq_o[7:0]` and `dq_o[15:8]`.
- R6: With `org_word` at 0, `dq_i[15]` is the lowest address bit, so byte address 2*`addr` + `dq_i[15]` is used. A value of 0 selects the low byte of word `addr` and a value of 1 selects its high byte. Data moves only on bits 7:0.
- R7: With `org_word` at 0, `dq_oe[1]` is 0 and `lb_n` and `ub_n` have no effect on reads or writes.
- R8: A lane that is not written keeps its previous contents, both beside a lane-masked or byte-wide write and across deselected cycles.
- R9: Read data comes combinationally from the addressed storage, so a read in the cycle after a write to the same location returns the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Model clock; storage updates on its rising edge |
| ce_n | input | 1 | Chip enable, active low |
| ce | input | 1 | Chip enable, active high |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| lb_n | input | 1 | Lane 0 enable in word organisation, active low |
| ub_n | input | 1 | Lane 1 enable in word organisation, active low |
| org_word | input | 1 | 1 selects word organisation, 0 selects byte organisation |
| addr | input | ADDR_W | Word address |
| dq_i | input | 2*LANE_W | Bus input; the top bit is the low address bit in byte organisation |
| dq_o | output | 2*LANE_W | Bus output data |
| dq_oe | output | 2 | Per-lane output enable (bit 0 for bits 7:0, bit 1 for bits 15:8) |

## Verification
The bench builds the block with ADDR_W = 6 and LANE_W = 8. A 64-word array is small enough to fill completely in a few cycles. With several thousand random accesses it also makes byte-wide and word-wide operations collide often on the same words and halves. As a result, lane-masked writes, writes that cross between organisations, and read-after-write in the next cycle all happen many times against the shadow model, not only in the directed cases.

// File: rtl/bwram_pkg.sv
package bwram_pkg;
   localparam int unsigned NUM_LANES = 2;

   typedef enum logic {
      ORG_BYTE = 1'b0,
      ORG_WORD = 1'b1
   } org_e;
endpackage

// File: rtl/bwram_ctrl.sv
module bwram_ctrl
   import bwram_pkg::*;
(
   input  logic                 ce_n,
   input  logic                 ce,
   input  logic                 we_n,
   input  logic                 oe_n,
   input  logic                 lb_n,
   input  logic                 ub_n,
   input  logic                 org_word,
   input  logic                 half_sel,
   output logic                 sel,
   output logic [NUM_LANES-1:0] lane_we,
   output logic [NUM_LANES-1:0] lane_act,
   output logic                 rd_en
);
   org_e org;

   always_comb begin
      org = org_e'(org_word);
      sel = ~ce_n & ce;
      if (org == ORG_WORD) begin
         lane_act = {~ub_n, ~lb_n};
      end else begin
         lane_act = {half_sel, ~half_sel};
      end
      lane_we = (sel & ~we_n) ? lane_act : '0;
      rd_en   = sel & we_n & ~oe_n;
   end
endmodule

// File: rtl/bwram_store.sv
module bwram_store
   import bwram_pkg::*;
#(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned LANE_W = 8
) (
   input  logic                              clk,
   input  logic [ADDR_W-1:0]                 addr,
   input  logic [NUM_LANES-1:0]              lane_we,
   input  logic [NUM_LANES-1:0][LANE_W-1:0]  wdata,
   output logic [NUM_LANES-1:0][LANE_W-1:0]  rdata
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (lane_we[g]) begin
            mem[addr] <= wdata[g];
         end
      end

      assign rdata[g] = mem[addr];
   end
endmodule

// File: rtl/bwram_rdmux.sv
module bwram_rdmux
   import bwram_pkg::*;
#(
   parameter int unsigned LANE_W = 8
) (
   input  logic                              org_word,
   input  logic                              half_sel,
   input  logic                              rd_en,
   input  logic [NUM_LANES-1:0]              lane_act,
   input  logic [NUM_LANES-1:0][LANE_W-1:0]  rdata,
   output logic [NUM_LANES*LANE_W-1:0]       dq_o,
   output logic [NUM_LANES-1:0]              dq_oe
);
   always_comb begin
      if (org_word) begin
         dq_o  = rdata;
         dq_oe = rd_en ? lane_act : '0;
      end else begin
         dq_o  = {{LANE_W{1'b0}}, (half_sel ? rdata[1] : rdata[0])};
         dq_oe = {1'b0, rd_en};
      end
   end
endmodule

// File: rtl/bwram_top.sv
module bwram_top
   import bwram_pkg::*;
#(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned LANE_W = 8
) (
   input  logic                          clk,
   input  logic                          ce_n,
   input  logic                          ce,
   input  logic                          we_n,
   input  logic                          oe_n,
   input  logic                          lb_n,
   input  logic                          ub_n,
   input  logic                          org_word,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [NUM_LANES*LANE_W-1:0]   dq_i,
   output logic [NUM_LANES*LANE_W-1:0]   dq_o,
   output logic [NUM_LANES-1:0]          dq_oe
);
   localparam int unsigned DW = NUM_LANES * LANE_W;

   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
      $error("bwram_top: ADDR_W must lie in 1..16");
   end
   if (LANE_W < 2) begin : g_bad_lane
      $error("bwram_top: LANE_W must be at least 2");
   end

   logic                             half_sel;
   logic                             sel;
   logic                             rd_en;
   logic [NUM_LANES-1:0]             lane_we;
   logic [NUM_LANES-1:0]             lane_act;
   logic [NUM_LANES-1:0][LANE_W-1:0] wdata;
   logic [NUM_LANES-1:0][LANE_W-1:0] rdata;

   assign half_sel = dq_i[DW-1];

   always_comb begin
      if (org_word) begin
         wdata = dq_i;
      end else begin
         wdata = {dq_i[LANE_W-1:0], dq_i[LANE_W-1:0]};
      end
   end

   bwram_ctrl u_ctrl (
      .ce_n     (ce_n),
      .ce       (ce),
      .we_n     (we_n),
      .oe_n     (oe_n),
      .lb_n     (lb_n),
      .ub_n     (ub_n),
      .org_word (org_word),
      .half_sel (half_sel),
      .sel      (sel),
      .lane_we  (lane_we),
      .lane_act (lane_act),
      .rd_en    (rd_en)
   );

   bwram_store #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_store (
      .clk     (clk),
      .addr    (addr),
      .lane_we (lane_we),
      .wdata   (wdata),
      .rdata   (rdata)
   );

   bwram_rdmux #(.LANE_W(LANE_W)) u_rdmux (
      .org_word (org_word),
      .half_sel (half_sel),
      .rd_en    (rd_en),
      .lane_act (lane_act),
      .rdata    (rdata),
      .dq_o     (dq_o),
      .dq_oe    (dq_oe)
   );
endmodule

// File: rtl/bwram_chk.sv
module bwram_chk #(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned LANE_W = 8
) (
   input logic                clk,
   input logic                ce_n,
   input logic                ce,
   input logic                we_n,
   input logic                oe_n,
   input logic                lb_n,
   input logic                ub_n,
   input logic                org_word,
   input logic [ADDR_W-1:0]   addr,
   input logic [2*LANE_W-1:0] dq_i,
   input logic [2*LANE_W-1:0] dq_o,
   input logic [1:0]          dq_oe,
   input logic [1:0]          lane_we
);
   logic picked;
   logic wr_lo_word;
   logic rd_lo_word;

   assign picked     = ~ce_n & ce;
   assign wr_lo_word = picked & ~we_n & org_word & ~lb_n;
   assign rd_lo_word = picked & we_n & ~oe_n & org_word & ~lb_n;

   AST_DESEL_QUIET: assert property (@(posedge clk)
      !picked |-> (dq_oe == 2'b00) && (lane_we == 2'b00)); // R1
   AST_WRITE_NO_DRIVE: assert property (@(posedge clk)
      (picked && !we_n) |-> (dq_oe == 2'b00)); // R2
   AST_READ_GATE: assert property (@(posedge clk)
      (dq_oe != 2'b00) |-> (picked && we_n && !oe_n)); // R3
   AST_WORD_NO_LANE: assert property (@(posedge clk)
      (org_word && lb_n && ub_n) |-> (dq_oe == 2'b00) && (lane_we == 2'b00)); // R4
   AST_BYTE_ONE_LANE: assert property (@(posedge clk)
      !org_word |-> !dq_oe[1] && $onehot0(lane_we)); // R7
   AST_RAW_NEXT: assert property (@(posedge clk)
      (rd_lo_word && $past(wr_lo_word) && (addr == $past(addr)))
      |-> (dq_o[LANE_W-1:0] == $past(dq_i[LANE_W-1:0]))); // R9
endmodule

bind bwram_top bwram_chk #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_chk (
   .clk      (clk),
   .ce_n     (ce_n),
   .ce       (ce),
   .we_n     (we_n),
   .oe_n     (oe_n),
   .lb_n     (lb_n),
   .ub_n     (ub_n),
   .org_word (org_word),
   .addr     (addr),
   .dq_i     (dq_i),
   .dq_o     (dq_o),
   .dq_oe    (dq_oe),
   .lane_we  (lane_we)
);

// File: tb/bwram_top_bench.sv
module bwram_top_bench;
   localparam int unsigned AW    = 6;
   localparam int unsigned LW    = 8;
   localparam int unsigned DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          ce_n, ce, we_n, oe_n, lb_n, ub_n, org_word;
   logic [AW-1:0] addr;
   logic [15:0]   dq_i;
   logic [15:0]   dq_o;
   logic [1:0]    dq_oe;

   logic [15:0]   shadow [DEPTH];
   int            n_vec = 0;
   int            n_bad = 0;
   bit            done  = 1'b0;

   always #2 clk = ~clk;

   bwram_top #(.ADDR_W(AW), .LANE_W(LW)) u_bwram_top (
      .clk(clk), .ce_n(ce_n), .ce(ce), .we_n(we_n), .oe_n(oe_n),
      .lb_n(lb_n), .ub_n(ub_n), .org_word(org_word), .addr(addr),
      .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
   );

   function automatic logic [1:0] exp_oe(bit cen, bit c2, bit wen, bit oen,
                                         bit lbn, bit ubn, bit wd);
      bit rd;
      rd = !cen && c2 && wen && !oen;
      if (wd) return {rd && !ubn, rd && !lbn};
      return {1'b0, rd};
   endfunction

   function automatic logic [7:0] exp_lo(logic [AW-1:0] a, logic [15:0] d, bit wd);
      if (wd || !d[15]) return shadow[a][7:0];
      return shadow[a][15:8];
   endfunction

   task automatic check(string tag, logic [15:0] act, logic [15:0] expv);
      n_vec++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, expv);
      end
   endtask

   task automatic apply(string tag, bit cen, bit c2, bit wen, bit oen,
                        bit lbn, bit ubn, bit wd, logic [AW-1:0] a, logic [15:0] d);
      logic [1:0] eo;
      @(negedge clk);
      ce_n = cen; ce = c2; we_n = wen; oe_n = oen;
      lb_n = lbn; ub_n = ubn; org_word = wd; addr = a; dq_i = d;
      #1;
      eo = exp_oe(cen, c2, wen, oen, lbn, ubn, wd);
      check({tag, " oe"}, {14'd0, dq_oe}, {14'd0, eo});
      if (eo[0]) check({tag, " lo"}, {8'd0, dq_o[7:0]}, {8'd0, exp_lo(a, d, wd)});
      if (eo[1]) check({tag, " hi"}, {8'd0, dq_o[15:8]}, {8'd0, shadow[a][15:8]});
      @(posedge clk);
      if (!cen && c2 && !wen) begin
         if (wd) begin
            if (!lbn) shadow[a][7:0]  = d[7:0];
            if (!ubn) shadow[a][15:8] = d[15:8];
         end else if (d[15]) begin
            shadow[a][15:8] = d[7:0];
         end else begin
            shadow[a][7:0] = d[7:0];
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      ce_n = 1'b1; ce = 1'b0; we_n = 1'b1; oe_n = 1'b1;
      lb_n = 1'b1; ub_n = 1'b1; org_word = 1'b1; addr = '0; dq_i = '0;
      seed = $urandom(32'd20240611);
      // R1 initial state: deselected, nothing driven
      #1;
      check("R1 initial", {14'd0, dq_oe}, 16'd0);
      // fill every word
      for (int i = 0; i < DEPTH; i++) begin
         logic [15:0] v;
         v = 16'(i * 16'h1357 + 16'h0A5C);
         apply("R5 fill", 0, 1, 0, 1, 0, 0, 1, AW'(i), v);
      end
      for (int i = 0; i < DEPTH; i++) apply("R5 word read", 0, 1, 1, 0, 0, 0, 1, AW'(i), 16'h0);
      // R2 write with output enable active
      apply("R2 write oe low", 0, 1, 0, 0, 0, 0, 1, AW'(3), 16'hBEEF);
      apply("R9 read after write", 0, 1, 1, 0, 0, 0, 1, AW'(3), 16'h0);
      // R4 upper lane only, lower lane only, none
      apply("R4 ub write", 0, 1, 0, 1, 1, 0, 1, AW'(5), 16'h12_34);
      apply("R8 masked read", 0, 1, 1, 0, 0, 0, 1, AW'(5), 16'h0);
      apply("R4 lb write", 0, 1, 0, 1, 0, 1, 1, AW'(5), 16'h56_78);
      apply("R4 no lane write", 0, 1, 0, 1, 1, 1, 1, AW'(5), 16'hFFFF);
      apply("R4 no lane read", 0, 1, 1, 0, 1, 1, 1, AW'(5), 16'h0);
      apply("R4 lb read", 0, 1, 1, 0, 0, 1, 1, AW'(5), 16'h0);
      apply("R4 ub read", 0, 1, 1, 0, 1, 0, 1, AW'(5), 16'h0);
      // R1 deselected writes must not land
      apply("R1 ce_n high write", 1, 1, 0, 0, 0, 0, 1, AW'(5), 16'hDEAD);
      apply("R1 ce low write", 0, 0, 0, 0, 0, 0, 1, AW'(5), 16'hDEAD);
      apply("R8 retain", 0, 1, 1, 0, 0, 0, 1, AW'(5), 16'h0);
      // R3 output disabled
      apply("R3 oe high", 0, 1, 1, 1, 0, 0, 1, AW'(5), 16'h0);
      // R6 byte organisation, both halves
      apply("R6 byte read lo", 0, 1, 1, 0, 0, 0, 0, AW'(5), 16'h0000);
      apply("R6 byte read hi", 0, 1, 1, 0, 0, 0, 0, AW'(5), 16'h8000);
      // R7 byte write with both lane enables high
      apply("R7 byte write hi", 0, 1, 0, 1, 1, 1, 0, AW'(9), 16'h80C3);
      apply("R7 byte read hi", 0, 1, 1, 0, 1, 1, 0, AW'(9), 16'h8000);
      apply("R8 other half", 0, 1, 1, 0, 0, 0, 1, AW'(9), 16'h0);
      apply("R6 byte write lo", 0, 1, 0, 1, 0, 0, 0, AW'(9), 16'h7F3C);
      apply("R9 word after bytes", 0, 1, 1, 0, 0, 0, 1, AW'(9), 16'h0);
      // constrained random mix
      for (int k = 0; k < 4000; k++) begin
         bit cen, c2, wen, oen, lbn, ubn, wd;
         cen = ($urandom % 8) == 0;
         c2  = ($urandom % 8) != 0;
         wen = ($urandom % 5) >= 2;
         oen = ($urandom % 4) == 0;
         lbn = ($urandom % 3) == 0;
         ubn = ($urandom % 3) == 0;
         wd  = $urandom % 2;
         apply("R3 R4 R6 R8 random", cen, c2, wen, oen, lbn, ubn, wd,
               AW'($urandom), 16'($urandom));
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule